// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives the control pins of an 8-bit asynchronous external memory or NAND flash port. A host asks for one byte access at a time over a level request / pulse acknowledge port. The host names the chip select, the direction, and whether the byte is data, a command or an address. The sequencer then walks through a setup phase, a strobe phase and a hold phase. Chip select stays active for all three phases. The read or write enable is active only in the strobe phase. A turnaround gap follows before the next access can start.

Each chip select has its own 32-bit timing word. The read and write phase lengths are programmed independently in that word, and a field value of N gives N+1 clock cycles. Command and address bytes are marked by the command latch and address latch outputs, which stay steady across the whole access. The device ready pin passes through a synchronizer into a status output. The host polls that output before it issues a status command.

Top module: `amem_strobe_seq`

## Requirements
- R1: While reset is held and right after it, every chip select and both enables are high (inactive), the two latch outputs, the data output enable and ack are low, and rdata is zero.
- R2: A request is taken only while the block is idle or in the last turnaround cycle. The chip select, direction, kind and write byte present at that moment are kept for the whole access, so later changes on those inputs have no effect. Only the chip select `cs_sel` goes low, and timing comes from the word at `cfg_bus[32*cs_sel +: 32]`.
- R3: A write holds chip select low for WS+1 cycles before `mem_we_n` falls. The enable stays low for exactly WT+1 cycles, and chip select then stays low for WH+1 more cycles. WS is word bits 29:26, WT is bits 25:20 and WH is bits 19:17.
- R4: A read has the same shape on `mem_re_n`, with RS+1 setup cycles, RT+1 strobe cycles and RH+1 hold cycles. RS is word bits 16:13, RT is bits 12:7 and RH is bits 6:4.
- R5: rdata takes the value on `mem_dq_in` in the last cycle of the read strobe. It then holds that value until the next read completes.
- R6: `kind` is 2'b01 for a command, which raises `mem_cle`, and 2'b10 for an address, which raises `mem_ale`. Both 2'b00 and 2'b11 are data and keep both latch outputs low. The chosen latch level is steady for the whole chip-select window.
- R7: On a write, `mem_dq_oe` is high and `mem_dq_out` carries the latched byte for the whole chip-select window. On a read, `mem_dq_oe` stays low.
- R8: `ack` is high for one cycle, and that cycle is the last hold cycle of the access.
- R9: After an access, chip select stays high for at least TA+1 cycles, where TA is bits 3:2 of that access's word. If the host keeps `req` high, the next access begins after exactly TA+1 such cycles.
- R10: Word bits 31, 30 and 1:0 have no effect on any output.
- R11: `rdy_status` equals `mem_rdy` as it was two clock edges earlier.
- R12: At most one chip select is low at any time, and `mem_re_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ack |
| wr_en | input | 1 | 1 = write, 0 = read |
| kind | input | 2 | 00/11 data, 01 command, 10 address |
| cs_sel | input | CS_W | Chip select index |
| wdata | input | DQ_W | Byte to write |
| ack | output | 1 | Pulse on the last hold cycle |
| rdata | output | DQ_W | Byte captured by the last read |
| cfg_bus | input | 32*NUM_CS | Timing words, one per chip select |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_re_n | output | 1 | Active-low read enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_cle | output | 1 | Command latch enable |
| mem_ale | output | 1 | Address latch enable |
| mem_dq_out | output | DQ_W | Write data to the pins |
| mem_dq_oe | output | 1 | Data pin output enable |
| mem_dq_in | input | DQ_W | Read data from the pins |
| mem_rdy | input | 1 | Asynchronous device ready |
| rdy_status | output | 1 | Synchronized ready bit |

## Verification
The hardest case to reach is the handoff inside the turnaround gap. Here a held request must be taken in the final gap cycle, with no extra idle cycle, and the gap length must come from the finished access's chip select and not from the new one. The bench keeps `req` high across the ack. It swaps in the next request's fields in the same cycle and counts the cycles in which chip select is high. It does this twice, once leaving a word with TA=3 and once leaving a word with TA=0. Capture timing is checked by a pin model whose read byte changes on every strobe cycle, so only a sample taken in the final strobe cycle gives the expected byte.

// File: rtl/amem_pkg.sv
package amem_pkg;

   localparam int CNT_W = 6;

   localparam int WS_LO = 26, WS_W = 4;
   localparam int WT_LO = 20, WT_W = 6;
   localparam int WH_LO = 17, WH_W = 3;
   localparam int RS_LO = 13, RS_W = 4;
   localparam int RT_LO = 7,  RT_W = 6;
   localparam int RH_LO = 4,  RH_W = 3;
   localparam int TA_LO = 2,  TA_W = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_GAP
   } amem_phase_e;

   typedef enum logic [1:0] {
      KIND_DATA  = 2'b00,
      KIND_CMD   = 2'b01,
      KIND_ADDR  = 2'b10,
      KIND_DATA2 = 2'b11
   } amem_kind_e;

   typedef struct packed {
      logic [CNT_W-1:0] setup;
      logic [CNT_W-1:0] strobe;
      logic [CNT_W-1:0] hold;
      logic [CNT_W-1:0] gap;
   } amem_timing_t;

   function automatic amem_timing_t pick_timing(input logic [31:0] w, input logic is_wr);
      amem_timing_t t;
      if (is_wr) begin
         t.setup  = CNT_W'(w[WS_LO +: WS_W]);
         t.strobe = CNT_W'(w[WT_LO +: WT_W]);
         t.hold   = CNT_W'(w[WH_LO +: WH_W]);
      end else begin
         t.setup  = CNT_W'(w[RS_LO +: RS_W]);
         t.strobe = CNT_W'(w[RT_LO +: RT_W]);
         t.hold   = CNT_W'(w[RH_LO +: RH_W]);
      end
      t.gap = CNT_W'(w[TA_LO +: TA_W]);
      return t;
   endfunction

endpackage

// File: rtl/amem_cfg_select.sv
module amem_cfg_select
   import amem_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int CFG_W  = 32,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic [NUM_CS*CFG_W-1:0] cfg_bus,
   input  logic [CS_W-1:0]         cs_sel,
   input  logic                    wr_en,
   output amem_timing_t            timing
);

   logic [CFG_W-1:0] words [NUM_CS];
   logic [CFG_W-1:0] chosen;

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_word
         assign words[g] = cfg_bus[g*CFG_W +: CFG_W];
      end
   endgenerate

   generate
      if (NUM_CS == (1 << CS_W)) begin : g_full
         assign chosen = words[cs_sel];
      end else begin : g_part
         always_comb begin
            chosen = words[0];
            for (int i = 0; i < NUM_CS; i++) begin
               if (cs_sel == CS_W'(i)) chosen = words[i];
            end
         end
      end
   endgenerate

   // mode bits 31:30 and width bits 1:0 do not take part in timing
   logic unused_mode_bits;
   assign unused_mode_bits = ^{chosen[31:30], chosen[1:0]};

   assign timing = pick_timing(chosen, wr_en);

endmodule

// File: rtl/amem_rdy_sync.sv
module amem_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/amem_phase_fsm.sv
module amem_phase_fsm
   import amem_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int DQ_W   = 8,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            wr_en,
   input  logic [1:0]      kind,
   input  logic [CS_W-1:0] cs_sel,
   input  logic [DQ_W-1:0] wdata,
   input  amem_timing_t    timing,
   input  logic [DQ_W-1:0] dq_in,
   output amem_phase_e     phase,
   output logic            last_cnt,
   output logic [CS_W-1:0] cs_q,
   output logic            wr_q,
   output logic [1:0]      kind_q,
   output logic [DQ_W-1:0] wdata_q,
   output logic [DQ_W-1:0] rdata_q
);

   logic [CNT_W-1:0] cnt;
   amem_timing_t     tim_q;
   logic             take;

   assign last_cnt = (cnt == '0);
   assign take     = req && ((phase == PH_IDLE) || ((phase == PH_GAP) && last_cnt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         tim_q   <= '0;
         cs_q    <= '0;
         wr_q    <= 1'b0;
         kind_q  <= KIND_DATA;
         wdata_q <= '0;
         rdata_q <= '0;
      end else if (take) begin
         phase   <= PH_SETUP;
         cnt     <= timing.setup;
         tim_q   <= timing;
         cs_q    <= cs_sel;
         wr_q    <= wr_en;
         kind_q  <= kind;
         wdata_q <= wdata;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               cnt <= '0;
            end
            PH_SETUP: begin
               if (last_cnt) begin
                  phase <= PH_STROBE;
                  cnt   <= tim_q.strobe;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (last_cnt) begin
                  phase <= PH_HOLD;
                  cnt   <= tim_q.hold;
                  if (!wr_q) rdata_q <= dq_in;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (last_cnt) begin
                  phase <= PH_GAP;
                  cnt   <= tim_q.gap;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_GAP: begin
               if (last_cnt) phase <= PH_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
   import amem_pkg::*;
#(
   parameter int NUM_CS      = 4,
   parameter int DQ_W        = 8,
   parameter int CFG_W       = 32,
   parameter int SYNC_STAGES = 2,
   localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req,
   input  logic                    wr_en,
   input  logic [1:0]              kind,
   input  logic [CS_W-1:0]         cs_sel,
   input  logic [DQ_W-1:0]         wdata,
   output logic                    ack,
   output logic [DQ_W-1:0]         rdata,
   input  logic [NUM_CS*CFG_W-1:0] cfg_bus,
   output logic [NUM_CS-1:0]       mem_cs_n,
   output logic                    mem_re_n,
   output logic                    mem_we_n,
   output logic                    mem_cle,
   output logic                    mem_ale,
   output logic [DQ_W-1:0]         mem_dq_out,
   output logic                    mem_dq_oe,
   input  logic [DQ_W-1:0]         mem_dq_in,
   input  logic                    mem_rdy,
   output logic                    rdy_status
);

   generate
      if (NUM_CS < 1)       begin : g_bad_cs   $error("NUM_CS must be at least 1");    end
      if (DQ_W != 8)        begin : g_bad_dq   $error("only an 8-bit bus is handled"); end
      if (CFG_W != 32)      begin : g_bad_cfg  $error("timing word must be 32 bits");  end
      if (SYNC_STAGES < 2)  begin : g_bad_sync $error("SYNC_STAGES must be 2 or more"); end
   endgenerate

   amem_timing_t    timing;
   amem_phase_e     phase;
   logic            last_cnt;
   logic [CS_W-1:0] cs_q;
   logic            wr_q;
   logic [1:0]      kind_q;
   logic [DQ_W-1:0] wdata_q;
   logic            window;
   logic            strobe;

   amem_cfg_select #(
      .NUM_CS (NUM_CS),
      .CFG_W  (CFG_W)
   ) u_cfg (
      .cfg_bus (cfg_bus),
      .cs_sel  (cs_sel),
      .wr_en   (wr_en),
      .timing  (timing)
   );

   amem_phase_fsm #(
      .NUM_CS (NUM_CS),
      .DQ_W   (DQ_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .wr_en    (wr_en),
      .kind     (kind),
      .cs_sel   (cs_sel),
      .wdata    (wdata),
      .timing   (timing),
      .dq_in    (mem_dq_in),
      .phase    (phase),
      .last_cnt (last_cnt),
      .cs_q     (cs_q),
      .wr_q     (wr_q),
      .kind_q   (kind_q),
      .wdata_q  (wdata_q),
      .rdata_q  (rdata)
   );

   amem_rdy_sync #(
      .STAGES (SYNC_STAGES)
   ) u_rdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (mem_rdy),
      .sync_out (rdy_status)
   );

   assign window = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign strobe = (phase == PH_STROBE);

   generate
      for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
         assign mem_cs_n[c] = !(window && (cs_q == CS_W'(c)));
      end
   endgenerate

   assign mem_we_n   = !(strobe && wr_q);
   assign mem_re_n   = !(strobe && !wr_q);
   assign mem_cle    = window && (kind_q == KIND_CMD);
   assign mem_ale    = window && (kind_q == KIND_ADDR);
   assign mem_dq_oe  = window && wr_q;
   assign mem_dq_out = wdata_q;
   assign ack        = (phase == PH_HOLD) && last_cnt;

endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk #(
   parameter int NUM_CS      = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic [NUM_CS-1:0] mem_cs_n,
   input logic              mem_re_n,
   input logic              mem_we_n,
   input logic              mem_cle,
   input logic              mem_ale,
   input logic              mem_dq_oe,
   input logic              mem_rdy,
   input logic              rdy_status
);

   logic [1:0] since_rst;
   logic       cs_any;

   assign cs_any = (mem_cs_n != '1);

   always_ff @(posedge clk) begin
      if (!rst_n)                  since_rst <= '0;
      else if (since_rst != 2'd2)  since_rst <= since_rst + 1'b1;
   end

   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n)); // R12
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_re_n && !mem_we_n)); // R12
   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_re_n || !mem_we_n) |-> cs_any); // R3
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_cle && mem_ale)); // R6
   AST_LATCH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_any && $past(cs_any) && !$past(ack)) |-> ($stable(mem_cle) && $stable(mem_ale))); // R6
   AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (cs_any && mem_re_n)); // R7
   AST_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (cs_any && mem_re_n && mem_we_n)); // R8
   AST_GAP_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !cs_any); // R9

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         AST_RDY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd2) |-> (rdy_status == $past(mem_rdy, 2))); // R11
      end
   endgenerate

endmodule

bind amem_strobe_seq amem_strobe_seq_chk #(
   .NUM_CS      (NUM_CS),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack        (ack),
   .mem_cs_n   (mem_cs_n),
   .mem_re_n   (mem_re_n),
   .mem_we_n   (mem_we_n),
   .mem_cle    (mem_cle),
   .mem_ale    (mem_ale),
   .mem_dq_oe  (mem_dq_oe),
   .mem_rdy    (mem_rdy),
   .rdy_status (rdy_status)
);

// File: tb/amem_strobe_seq_test.sv
module amem_strobe_seq_test;

   localparam int NCS = 4;
   localparam int CSW = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             req;
   logic             wr_en;
   logic [1:0]       kind;
   logic [CSW-1:0]   cs_sel;
   logic [7:0]       wdata;
   logic             ack;
   logic [7:0]       rdata;
   logic [NCS*32-1:0] cfg_bus;
   logic [NCS-1:0]   mem_cs_n;
   logic             mem_re_n, mem_we_n, mem_cle, mem_ale, mem_dq_oe;
   logic [7:0]       mem_dq_out, mem_dq_in;
   logic             mem_rdy, rdy_status;

   int n_chk = 0;
   int n_bad = 0;

   int ws [NCS], wt [NCS], wh [NCS], rs [NCS], rt [NCS], rh [NCS], ta [NCS];

   always #10 clk = ~clk;

   amem_strobe_seq uut (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .kind(kind),
      .cs_sel(cs_sel), .wdata(wdata), .ack(ack), .rdata(rdata),
      .cfg_bus(cfg_bus), .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n),
      .mem_we_n(mem_we_n), .mem_cle(mem_cle), .mem_ale(mem_ale),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
      .mem_rdy(mem_rdy), .rdy_status(rdy_status)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int a, input int b, input int c, input int d,
                                      input int e, input int f, input int g, input logic [3:0] extra);
      return {extra[3:2], 4'(a), 6'(b), 3'(c), 4'(d), 6'(e), 3'(f), 2'(g), extra[1:0]};
   endfunction

   task automatic set_cs(input int i, input int a, input int b, input int c, input int d,
                         input int e, input int f, input int g, input logic [3:0] extra);
      ws[i] = a; wt[i] = b; wh[i] = c; rs[i] = d; rt[i] = e; rh[i] = f; ta[i] = g;
      cfg_bus[i*32 +: 32] = mk(a, b, c, d, e, f, g, extra);
   endtask

   // Runs one access; inputs are scrambled once chip select falls (R2)
   task automatic run_acc(input int cs, input bit wr, input logic [1:0] k, input logic [7:0] dat,
                          input logic [7:0] base, input bit keep,
                          output int lead, output int cs_cyc, output int pre, output int strb,
                          output int post, output bit bad_lat, output bit bad_oe,
                          output bit bad_cs, output bit bad_typ, output bit timeout);
      bit started = 0, done = 0;
      int rc = 0, n = 0;
      lead = 0; cs_cyc = 0; pre = 0; strb = 0; post = 0;
      bad_lat = 0; bad_oe = 0; bad_cs = 0; bad_typ = 0; timeout = 0;
      req = 1'b1; cs_sel = CSW'(cs); wr_en = wr; kind = k; wdata = dat; mem_dq_in = base;
      while (!done && n < 2000) begin
         bit csl, st, wrong;
         @(negedge clk);
         n++;
         csl = (mem_cs_n[cs] == 1'b0);
         if ((mem_cs_n | NCS'(1 << cs)) != '1) bad_cs = 1;
         if (!mem_re_n && !mem_we_n) bad_typ = 1;
         if (!csl) begin
            if (!started) lead++;
            else bad_cs = 1;
            if (ack) bad_typ = 1;
         end else begin
            if (!started) begin
               cs_sel = CSW'((cs + 1) % NCS); wdata = ~dat; wr_en = !wr; kind = k ^ 2'b01;
            end
            started = 1;
            cs_cyc++;
            st    = wr ? !mem_we_n : !mem_re_n;
            wrong = wr ? !mem_re_n : !mem_we_n;
            if (wrong) bad_typ = 1;
            if (st) begin
               strb++;
               if (post > 0) bad_typ = 1;
            end else if (strb == 0) pre++;
            else post++;
            if (mem_cle != (k == 2'b01) || mem_ale != (k == 2'b10)) bad_lat = 1;
            if (mem_dq_oe != wr) bad_oe = 1;
            if (wr && mem_dq_out != dat) bad_oe = 1;
            if (ack) done = 1;
         end
         if (!wr && !mem_re_n) begin
            rc++;
            mem_dq_in = base + 8'(rc);
         end
      end
      if (!done) timeout = 1;
      if (!keep) req = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic acc_check(input string tag, input int cs, input bit wr, input logic [1:0] k,
                            input logic [7:0] dat, input logic [7:0] base, input bit keep,
                            output int lead);
      int cc, pre, strb, post, s, t, h;
      bit bl, bo, bc, bt, to;
      run_acc(cs, wr, k, dat, base, keep, lead, cc, pre, strb, post, bl, bo, bc, bt, to);
      s = wr ? ws[cs] : rs[cs]; t = wr ? wt[cs] : rt[cs]; h = wr ? wh[cs] : rh[cs];
      check(!to, {tag, " R8 ack seen"}, 0, 1);
      check(pre == s + 1,  {tag, wr ? " R3 write setup" : " R4 read setup"}, pre, s + 1);
      check(strb == t + 1, {tag, wr ? " R3 write strobe" : " R4 read strobe"}, strb, t + 1);
      check(post == h + 1, {tag, wr ? " R3 write hold (R8 ack last)" : " R4 read hold (R8 ack last)"}, post, h + 1);
      check(cc == s + t + h + 3, {tag, " R2 cs window"}, cc, s + t + h + 3);
      check(!bl, {tag, " R6 latch outputs"}, bl, 0);
      check(!bo, {tag, " R7 data drive"}, bo, 0);
      check(!bc, {tag, " R12 chip select"}, bc, 0);
      check(!bt, {tag, " R12 strobe kind"}, bt, 0);
      if (!wr) check(rdata == 8'(base + 8'(t + 1)), {tag, " R5 capture"}, rdata, 8'(base + 8'(t + 1)));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle(3);
      check(mem_cs_n == '1 && mem_re_n && mem_we_n, "R1 strobes idle", {mem_cs_n, mem_re_n, mem_we_n}, 63);
      check(!mem_cle && !mem_ale && !mem_dq_oe && !ack, "R1 control low",
            {mem_cle, mem_ale, mem_dq_oe, ack}, 0);
      check(rdata == 8'h00, "R1 rdata", rdata, 0);
      rst_n = 1'b1;
      idle(2);
      check(mem_cs_n == '1 && !ack, "R1 after release", mem_cs_n, 15);
   endtask

   task automatic t_basic();
      int ld;
      acc_check("wr cs0", 0, 1'b1, 2'b00, 8'hA5, 8'h00, 1'b0, ld);
      check(ld == 0, "R2 immediate start", ld, 0);
      idle(1);
      check(mem_cs_n == '1, "R8 cs high after ack", mem_cs_n, 15);
      idle(6);
      acc_check("rd cs0", 0, 1'b0, 2'b00, 8'h40, 8'h40, 1'b0, ld);
      idle(8);
      check(rdata == 8'h46, "R5 rdata held", rdata, 8'h46);
   endtask

   task automatic t_kinds();
      int ld;
      acc_check("cmd cs1", 1, 1'b1, 2'b01, 8'h70, 8'h00, 1'b0, ld);
      idle(6);
      acc_check("addr cs1", 1, 1'b1, 2'b10, 8'h12, 8'h00, 1'b0, ld);
      idle(6);
      acc_check("data11 cs1", 1, 1'b1, 2'b11, 8'h3C, 8'h00, 1'b0, ld);
      idle(6);
      acc_check("rd cs1", 1, 1'b0, 2'b00, 8'h00, 8'h90, 1'b0, ld);
      idle(6);
   endtask

   task automatic t_ignored_bits();
      int ld;
      acc_check("R10 wr cs2", 2, 1'b1, 2'b00, 8'h5A, 8'h00, 1'b0, ld);
      idle(6);
      acc_check("R10 rd cs2", 2, 1'b0, 2'b01, 8'h00, 8'h20, 1'b0, ld);
      idle(6);
   endtask

   task automatic t_max();
      int ld;
      acc_check("max wr cs3", 3, 1'b1, 2'b00, 8'hFF, 8'h00, 1'b0, ld);
      idle(6);
      acc_check("max rd cs3", 3, 1'b0, 2'b00, 8'h00, 8'h80, 1'b0, ld);
      idle(6);
   endtask

   task automatic t_turnaround();
      int ld;
      acc_check("chain a cs0", 0, 1'b1, 2'b00, 8'h11, 8'h00, 1'b1, ld);
      acc_check("chain b cs1", 1, 1'b0, 2'b00, 8'h00, 8'h30, 1'b1, ld);
      check(ld == ta[0] + 1, "R9 gap from cs0 word", ld, ta[0] + 1);
      acc_check("chain c cs0", 0, 1'b1, 2'b10, 8'h22, 8'h00, 1'b1, ld);
      check(ld == ta[1] + 1, "R9 gap from cs1 word", ld, ta[1] + 1);
      acc_check("chain d cs2", 2, 1'b1, 2'b00, 8'h33, 8'h00, 1'b0, ld);
      check(ld == ta[0] + 1, "R9 gap after cs0 again", ld, ta[0] + 1);
      idle(6);
   endtask

   task automatic t_ready();
      mem_rdy = 1'b1;
      @(negedge clk);
      check(rdy_status == 1'b0, "R11 one edge after rise", rdy_status, 0);
      @(negedge clk);
      check(rdy_status == 1'b1, "R11 two edges after rise", rdy_status, 1);
      mem_rdy = 1'b0;
      @(negedge clk);
      check(rdy_status == 1'b1, "R11 one edge after fall", rdy_status, 1);
      @(negedge clk);
      check(rdy_status == 1'b0, "R11 two edges after fall", rdy_status, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req = 1'b0; wr_en = 1'b0; kind = 2'b00; cs_sel = '0;
      wdata = '0; mem_dq_in = '0; mem_rdy = 1'b0; cfg_bus = '0;
      set_cs(0, 1, 3, 1, 1, 5, 1, 3, 4'b0000);
      set_cs(1, 0, 0, 0, 2, 1, 2, 0, 4'b0000);
      set_cs(2, 1, 3, 1, 1, 5, 1, 3, 4'b1111);
      set_cs(3, 15, 63, 7, 15, 63, 7, 2, 4'b0000);
      @(negedge clk);
      t_reset();
      t_basic();
      t_kinds();
      t_ignored_bits();
      t_max();
      t_turnaround();
      t_ready();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule